// File: doc/BRIEF.md
# Split-Word Global Memory Transfer Controller

This block moves 16-bit or 32-bit words between a processor and a shared global RAM that is only 16 bits wide. The processor presents a start pulse with an address, a direction and a size. The block registers these, raises a memory request and waits for the arbiter's grant. Once grant arrives, it enables its address outputs and drives the read/write strobe for one granted cycle per 16-bit half.

A 32-bit word is moved as two consecutive 16-bit accesses. The second access uses the first address with address bit 1 inverted. A half flag records which half is in progress and steers the data. On a read, the first half fills the upper 16 bits of the assembled word and the second half fills the lower 16 bits. Read as a floating-point value, the assembled word holds a 24-bit mantissa in its upper bits and an 8-bit exponent in its low byte. The block also records whether the start address was odd.

Top module: `split_word_xfer`

## Requirements
- R1: After reset, memReq, addrEn, memWe, secondHalf and done are all 0.
- R2: startReq while idle registers busAddr, wideMode, writeDir and wrData, and memReq is 1 from the next cycle on. memReq stays 1 until the clock edge at which the last half is granted. A startReq while memReq is 1 is ignored.
- R3: The first half uses the registered address. The second half of a 32-bit access uses that address with bit 1 inverted.
- R4: addrEn is 1 only while memReq and memGrant are both 1. While addrEn is 1, memWe is 1 for a write (writeDir=1) and 0 for a read. Each granted clock edge completes one half.
- R5: addrOdd equals bit 0 of the address registered at start.
- R6: On a 32-bit read, the first half's memRdata goes to rdWord[31:16] and the second half's goes to rdWord[15:0]. mantissa equals rdWord[31:8] and exponent equals rdWord[7:0].
- R7: On a 32-bit write, memWdata is wrData[31:16] during the first half and wrData[15:0] during the second half.
- R8: A 16-bit access (wideMode=0) takes one granted cycle and secondHalf stays 0. A read loads rdWord with {16'h0, memRdata}. A write drives wrData[15:0].
- R9: done is 1 for exactly one cycle: the cycle after the clock edge at which the last half is granted.
- R10: During a 32-bit access, secondHalf is 0 for the first half and 1 from the first granted edge until the transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse from the processor |
| wideMode | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| writeDir | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Start address from the processor bus |
| wrData | input | 32 | Write data |
| memGrant | input | 1 | Grant from the RAM arbiter |
| memRdata | input | 16 | Read data from the RAM |
| memReq | output | 1 | Memory request, also the busy indication |
| addrEn | output | 1 | Address outputs valid (granted cycle) |
| memWe | output | 1 | Read/write strobe, 1 = write |
| memAddr | output | 12 | Address for the current half |
| memWdata | output | 16 | Write data for the current half |
| secondHalf | output | 1 | Half flag: 1 while the second half is in progress |
| addrOdd | output | 1 | Start address was odd |
| done | output | 1 | One-cycle completion pulse |
| rdWord | output | 32 | Assembled read word |
| mantissa | output | 24 | Mantissa field of rdWord |
| exponent | output | 8 | Exponent field of rdWord |

## Verification
The assertions check on every cycle that:
- the request is held while a half is still pending, and a start during a transfer leaves the registered size and direction unchanged;
- done is a single-cycle pulse that follows a granted cycle;
- the half flag rises only after a granted first half and never rises on a 16-bit access;
- the address flips bit 1 exactly when the half flag rises;
- the odd flag matches the start address.

The data placement needs the bench's scenarios to show it: which input half lands in which part of rdWord, which wrData half is driven, and the mantissa and exponent split. So do the exact cycle of done, the handling of varying grant delays, and a second start that arrives mid-transfer.

// File: rtl/swx_pkg.sv
package swx_pkg;
  typedef struct packed {
    logic load;       // register start parameters
    logic capHi;      // capture first half of a wide read
    logic capLo;      // capture second half of a wide read
    logic capOnly;    // capture single half of a narrow read
    logic useSecond;  // address the second half
    logic drvHi;      // drive upper write half
  } swxStrobe_t;
endpackage

// File: rtl/swx_ctrl.sv
module swx_ctrl
  import swx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       wideMode,
  input  logic       writeDir,
  input  logic       memGrant,
  output swxStrobe_t strobe,
  output logic       memReq,
  output logic       addrEn,
  output logic       memWe,
  output logic       secondHalf,
  output logic       done
);
  logic busyQ, wideQ, writeQ, halfQ, doneQ;
  logic grantHit, lastHalf, startHit;

  assign startHit = !busyQ && startReq;
  assign grantHit = busyQ && memGrant;
  assign lastHalf = !wideQ || halfQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      wideQ  <= 1'b0;
      writeQ <= 1'b0;
      halfQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (startHit) begin
        busyQ  <= 1'b1;
        wideQ  <= wideMode;
        writeQ <= writeDir;
        halfQ  <= 1'b0;
      end else if (grantHit) begin
        if (lastHalf) begin
          busyQ <= 1'b0;
          halfQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          halfQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load      = startHit;
    strobe.capHi     = grantHit && !writeQ && wideQ && !halfQ;
    strobe.capLo     = grantHit && !writeQ && wideQ && halfQ;
    strobe.capOnly   = grantHit && !writeQ && !wideQ;
    strobe.useSecond = halfQ;
    strobe.drvHi     = wideQ && !halfQ;
  end

  assign memReq     = busyQ;
  assign addrEn     = grantHit;
  assign memWe      = grantHit && writeQ;
  assign secondHalf = halfQ;
  assign done       = doneQ;

  // R2: request held while a half is still pending
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !(memGrant && lastHalf) |=> memReq);
  // R2: start during a transfer does not change size or direction
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && startReq |=> $stable(wideQ) && $stable(writeQ));
  // R9: done lasts a single cycle and follows a granted cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReq && memGrant));
  // R10: half flag rises only after a granted first half of a wide access
  p_half_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secondHalf) |-> $past(addrEn) && wideQ);
  // R8: narrow access never enters the second half
  p_narrow_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !wideQ |-> !secondHalf);
endmodule

// File: rtl/swx_datapath.sv
module swx_datapath
  import swx_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int HALF_W   = 16,
  parameter int EXP_W    = 8,
  parameter int FLIP_BIT = 1,
  localparam int WORD_W  = 2 * HALF_W,
  localparam int MANT_W  = WORD_W - EXP_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  swxStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [HALF_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [HALF_W-1:0] memWdata,
  output logic              addrOdd,
  output logic [WORD_W-1:0] rdWord,
  output logic [MANT_W-1:0] mantissa,
  output logic [EXP_W-1:0]  exponent
);
  localparam logic [ADDR_W-1:0] FLIP_MASK = ADDR_W'(1) << FLIP_BIT;

  logic [ADDR_W-1:0] baseQ;
  logic [WORD_W-1:0] wdataQ;
  logic              oddQ;
  logic [WORD_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      wdataQ <= '0;
      oddQ   <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (strobe.load) begin
        baseQ  <= busAddr;
        wdataQ <= wrData;
        oddQ   <= busAddr[0];
      end
      if (strobe.capHi)   rdQ[WORD_W-1:HALF_W] <= memRdata;
      if (strobe.capLo)   rdQ[HALF_W-1:0]      <= memRdata;
      if (strobe.capOnly) rdQ <= {{HALF_W{1'b0}}, memRdata};
    end
  end

  assign memAddr  = strobe.useSecond ? (baseQ ^ FLIP_MASK) : baseQ;
  assign memWdata = strobe.drvHi ? wdataQ[WORD_W-1:HALF_W] : wdataQ[HALF_W-1:0];
  assign addrOdd  = oddQ;
  assign rdWord   = rdQ;
  assign mantissa = rdQ[WORD_W-1:EXP_W];
  assign exponent = rdQ[EXP_W-1:0];

  // R3: second-half address is the first with the flip bit inverted
  p_addr_flip_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.useSecond) |-> memAddr == ($past(memAddr) ^ FLIP_MASK));
  // R5: odd flag follows the loaded address
  p_odd_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobe.load) |-> addrOdd == $past(busAddr[0]));
endmodule

// File: rtl/split_word_xfer.sv
module split_word_xfer
  import swx_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int HALF_W   = 16,
  parameter int EXP_W    = 8,
  parameter int FLIP_BIT = 1,
  localparam int WORD_W  = 2 * HALF_W,
  localparam int MANT_W  = WORD_W - EXP_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              wideMode,
  input  logic              writeDir,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              memGrant,
  input  logic [HALF_W-1:0] memRdata,
  output logic              memReq,
  output logic              addrEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [HALF_W-1:0] memWdata,
  output logic              secondHalf,
  output logic              addrOdd,
  output logic              done,
  output logic [WORD_W-1:0] rdWord,
  output logic [MANT_W-1:0] mantissa,
  output logic [EXP_W-1:0]  exponent
);
  swxStrobe_t strobe;

  swx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wideMode(wideMode),
    .writeDir(writeDir), .memGrant(memGrant), .strobe(strobe),
    .memReq(memReq), .addrEn(addrEn), .memWe(memWe),
    .secondHalf(secondHalf), .done(done)
  );

  swx_datapath #(
    .ADDR_W(ADDR_W), .HALF_W(HALF_W), .EXP_W(EXP_W), .FLIP_BIT(FLIP_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .wrData(wrData), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .addrOdd(addrOdd), .rdWord(rdWord),
    .mantissa(mantissa), .exponent(exponent)
  );
endmodule

// File: tb/split_word_xfer_test.sv
`timescale 1ns/1ps
module split_word_xfer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, wideMode = 1'b0, writeDir = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] wrData = '0;
  logic        memGrant = 1'b0;
  logic [15:0] memRdata = '0;
  logic        memReq, addrEn, memWe, secondHalf, addrOdd, done;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic [31:0] rdWord;
  logic [23:0] mantissa;
  logic [7:0]  exponent;

  int total = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  split_word_xfer uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wideMode(wideMode),
    .writeDir(writeDir), .busAddr(busAddr), .wrData(wrData),
    .memGrant(memGrant), .memRdata(memRdata), .memReq(memReq),
    .addrEn(addrEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .secondHalf(secondHalf), .addrOdd(addrOdd), .done(done),
    .rdWord(rdWord), .mantissa(mantissa), .exponent(exponent)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic        V_WIDE [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic        V_WR   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [11:0] V_ADDR [NV] = '{12'h100, 12'h203, 12'h041, 12'h0FE, 12'h002, 12'hFFF};
  localparam logic [31:0] V_WDAT [NV] = '{32'h0, 32'h12345678, 32'h0, 32'hCAFEBEEF, 32'h0, 32'h0};
  localparam logic [15:0] V_HI   [NV] = '{16'hA1B2, 16'h0, 16'h5A5A, 16'h0, 16'h8000, 16'hFFFF};
  localparam logic [15:0] V_LO   [NV] = '{16'hC3D4, 16'h0, 16'h0, 16'h0, 16'h7F81, 16'h0001};
  localparam int          V_GAP  [NV] = '{0, 2, 1, 0, 3, 0};

  task automatic runTxn(input logic wide, input logic wr, input logic [11:0] addr,
                        input logic [31:0] wdat, input logic [15:0] hi,
                        input logic [15:0] lo, input int gap, input bit poke);
    logic [31:0] expRd;
    @(negedge clk);
    startReq = 1'b1; wideMode = wide; writeDir = wr; busAddr = addr; wrData = wdat;
    memGrant = 1'b0;
    @(negedge clk);
    startReq = 1'b0; busAddr = ~addr; wrData = ~wdat; wideMode = ~wide; writeDir = ~wr;
    check(memReq == 1'b1, "R2 memReq after start", 32'(memReq), 32'd1);
    check(addrOdd == addr[0], "R5 addrOdd", 32'(addrOdd), 32'(addr[0]));
    for (int i = 0; i < gap; i++) begin
      #0.5;
      check(addrEn == 1'b0, "R4 addrEn without grant", 32'(addrEn), 32'd0);
      if (poke && i == 0) startReq = 1'b1;  // ignored: block is busy
      @(negedge clk);
      startReq = 1'b0;
      check(memReq == 1'b1, "R2 memReq held waiting", 32'(memReq), 32'd1);
    end
    memGrant = 1'b1; memRdata = hi;
    #0.5;
    check(addrEn == 1'b1, "R4 addrEn on grant", 32'(addrEn), 32'd1);
    check(memWe == wr, "R4 memWe direction", 32'(memWe), 32'(wr));
    check(memAddr == addr, "R3 first-half address", 32'(memAddr), 32'(addr));
    check(secondHalf == 1'b0, "R10 first half flag", 32'(secondHalf), 32'd0);
    if (wr) begin
      if (wide) check(memWdata == wdat[31:16], "R7 first write half", 32'(memWdata), 32'(wdat[31:16]));
      else      check(memWdata == wdat[15:0], "R8 narrow write data", 32'(memWdata), 32'(wdat[15:0]));
    end
    @(negedge clk);
    if (wide) begin
      memRdata = lo;
      #0.5;
      check(secondHalf == 1'b1, "R10 second half flag", 32'(secondHalf), 32'd1);
      check(memReq == 1'b1, "R2 memReq between halves", 32'(memReq), 32'd1);
      check(done == 1'b0, "R9 no done mid-word", 32'(done), 32'd0);
      check(memAddr == (addr ^ 12'h002), "R3 second-half address", 32'(memAddr), 32'(addr ^ 12'h002));
      if (wr) check(memWdata == wdat[15:0], "R7 second write half", 32'(memWdata), 32'(wdat[15:0]));
      @(negedge clk);
    end else begin
      check(secondHalf == 1'b0, "R8 narrow flag untouched", 32'(secondHalf), 32'd0);
    end
    memGrant = 1'b0;
    #0.5;
    check(done == 1'b1, "R9 done pulse", 32'(done), 32'd1);
    check(memReq == 1'b0, "R2 memReq dropped", 32'(memReq), 32'd0);
    check(secondHalf == 1'b0, "R10 flag cleared", 32'(secondHalf), 32'd0);
    if (!wr) begin
      expRd = wide ? {hi, lo} : {16'h0, hi};
      check(rdWord == expRd, wide ? "R6 wide read word" : "R8 narrow read word", rdWord, expRd);
      if (wide) begin
        check(mantissa == {hi, lo[15:8]}, "R6 mantissa", 32'(mantissa), 32'({hi, lo[15:8]}));
        check(exponent == lo[7:0], "R6 exponent", 32'(exponent), 32'(lo[7:0]));
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    startReq = 1'b1;  // held during reset: must not start a transfer
    @(negedge clk);
    check(memReq == 1'b0 && addrEn == 1'b0 && memWe == 1'b0,
          "R1 reset outputs", {29'd0, memReq, addrEn, memWe}, 32'd0);
    check(secondHalf == 1'b0 && done == 1'b0, "R1 reset flags",
          {30'd0, secondHalf, done}, 32'd0);
    startReq = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(memReq == 1'b0, "R1 idle after reset", 32'(memReq), 32'd0);

    for (int v = 0; v < NV; v++)
      runTxn(V_WIDE[v], V_WR[v], V_ADDR[v], V_WDAT[v], V_HI[v], V_LO[v], V_GAP[v], 1'b0);

    // R2: start during a wide read is ignored (size, address unchanged)
    runTxn(1'b1, 1'b0, 12'h3A5, 32'h0, 16'h1357, 16'h9BDF, 2, 1'b1);
    // R8: narrow read after wide read replaces the upper half with zero
    runTxn(1'b0, 1'b0, 12'h7FE, 32'h0, 16'hFACE, 16'h0, 0, 1'b1);
    // R4: grant with no request leaves the strobes low
    memGrant = 1'b1;
    #0.5;
    check(addrEn == 1'b0 && memWe == 1'b0, "R4 grant while idle",
          {30'd0, addrEn, memWe}, 32'd0);
    @(negedge clk);
    check(done == 1'b0 && memReq == 1'b0, "R9 no done while idle",
          {30'd0, done, memReq}, 32'd0);
    memGrant = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule